// File: doc/BRIEF.md
# Filtered PLL Lock Monitor

This block turns the raw lock indication of a PLL, which can chatter while the loop settles or under noise, into a clean two-state view of the link clock. The raw flag is first brought into the local clock domain through a flop synchronizer. A dwell filter then changes its state from unlocked to locked only when the synchronized flag has stayed high for a programmable number of consecutive cycles. It changes back to unlocked only when the flag has stayed low for a second, independent number of cycles. A flag that changes before its dwell is complete resets the run count.

The filtered state drives the serializer enable. A two-bit manual override can force that enable high or low, so that the serializer synchronizer can be re-armed by hand after a loss of lock. An 8-bit counter records each re-acquisition of lock, saturates at its maximum value, and is cleared by the PLL reset command. Every pin is plain control or status. The block has no data stream and therefore no valid/ready handshake.

Top module: `pll_lock_filter`

## Requirements
- R1: `lock_raw_o` equals `lock_raw_i` delayed by exactly two clock edges (two-flop synchronizer).
- R2: While `rst_n` is low and at the first sample after its release, `locked_o` is 0, `relock_cnt_o` is 0 and, with the override off, `ser_enable_o` is 0. The dwell run count is cleared.
- R3: In the unlocked state, `locked_o` rises at the edge where the synchronized flag has been sampled high for N consecutive edges, N = `lock_dwell_i`, with a value of 0 treated as 1.
- R4: In the locked state, `locked_o` falls at the edge where the synchronized flag has been sampled low for M consecutive edges, M = `unlock_dwell_i`, with a value of 0 treated as 1.
- R5: A synchronized flag that returns to the value matching the current state before its dwell is complete restarts the run from zero, so no state change occurs.
- R6: `relock_cnt_o` increases by exactly 1 at the same edge at which `locked_o` rises, and at no other time.
- R7: `pll_reset_i` high at an edge clears `relock_cnt_o` to 0, even if a relock occurs at that edge. It does not change `locked_o`.
- R8: `relock_cnt_o` holds at 255 on further relocks instead of wrapping.
- R9: With `ovr_en_i` = 0, `ser_enable_o` equals `locked_o`.
- R10: With `ovr_en_i` = 1, `ser_enable_o` equals `ovr_val_i` without delay, and `locked_o` continues to follow the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw_i | input | 1 | Raw, asynchronous PLL lock flag |
| lock_dwell_i | input | 8 | Consecutive high samples needed to declare lock (0 acts as 1) |
| unlock_dwell_i | input | 8 | Consecutive low samples needed to declare loss of lock (0 acts as 1) |
| pll_reset_i | input | 1 | PLL reset command; clears the relock counter |
| ovr_en_i | input | 1 | Selects manual control of the serializer enable |
| ovr_val_i | input | 1 | Forced serializer enable value when override is selected |
| lock_raw_o | output | 1 | Synchronized mirror of the raw flag |
| locked_o | output | 1 | Filtered lock state (1 = locked) |
| ser_enable_o | output | 1 | Serializer enable |
| relock_cnt_o | output | 8 | Saturating count of unlocked-to-locked transitions |

## Verification
The hardest condition to reach from the ports is saturation of the relock counter, because it needs 255 complete lock and unlock cycles. The stimulus reaches it by setting both dwells to 1 and toggling the raw flag in short bursts about three hundred times. A second hard case is a glitch that ends exactly one sample before the dwell completes. Pulse lengths are set relative to the programmed dwell so that the run stops at N-1 and at N, and the reference model tracks the result on every clock.

// File: rtl/plf_pkg.sv
package plf_pkg;
  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/plf_sync.sv
module plf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/plf_dwell_fsm.sv
module plf_dwell_fsm
  import plf_pkg::*;
#(
  parameter int DWELL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_i,
  input  logic [DWELL_W-1:0] lock_dwell_i,
  input  logic [DWELL_W-1:0] unlock_dwell_i,
  output logic               locked_o,
  output logic               relock_evt_o
);
  localparam logic [DWELL_W-1:0] ONE = DWELL_W'(1);

  lock_state_e        state_q, state_d;
  logic [DWELL_W-1:0] run_q, run_d;
  logic [DWELL_W-1:0] dwell_sel, dwell_eff;
  logic [DWELL_W:0]   run_inc;
  logic               opposing;

  assign dwell_sel = (state_q == ST_LOCKED) ? unlock_dwell_i : lock_dwell_i;
  assign dwell_eff = (dwell_sel == '0) ? ONE : dwell_sel;
  assign opposing  = (state_q == ST_LOCKED) ? !sample_i : sample_i;
  assign run_inc   = {1'b0, run_q} + {{DWELL_W{1'b0}}, 1'b1};

  always_comb begin
    state_d = state_q;
    run_d   = '0;
    if (opposing) begin
      if (run_inc >= {1'b0, dwell_eff}) begin
        state_d = (state_q == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
      end else begin
        run_d = run_inc[DWELL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_UNLOCKED;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
    end
  end

  assign locked_o     = (state_q == ST_LOCKED);
  assign relock_evt_o = (state_q == ST_UNLOCKED) && (state_d == ST_LOCKED);

  AST_LOCK_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(sample_i)); // R3
  AST_UNLOCK_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> !$past(sample_i)); // R4
  AST_RUN_BELOW_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != '0) |-> $past(opposing)); // R5
endmodule

// File: rtl/plf_relock_ctr.sv
module plf_relock_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != MAXV)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0)); // R7
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == MAXV && !clear_i) |=> (count_o == MAXV)); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> (count_o == '0 || count_o == $past(count_o) + CNT_W'(1))); // R6
endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
  parameter int DWELL_W     = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_raw_i,
  input  logic [DWELL_W-1:0] lock_dwell_i,
  input  logic [DWELL_W-1:0] unlock_dwell_i,
  input  logic               pll_reset_i,
  input  logic               ovr_en_i,
  input  logic               ovr_val_i,
  output logic               lock_raw_o,
  output logic               locked_o,
  output logic               ser_enable_o,
  output logic [CNT_W-1:0]   relock_cnt_o
);
  logic lock_sync;
  logic relock_evt;

  plf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lock_raw_i),
    .sync_o  (lock_sync)
  );

  plf_dwell_fsm #(.DWELL_W(DWELL_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_i       (lock_sync),
    .lock_dwell_i   (lock_dwell_i),
    .unlock_dwell_i (unlock_dwell_i),
    .locked_o       (locked_o),
    .relock_evt_o   (relock_evt)
  );

  plf_relock_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (pll_reset_i),
    .inc_i   (relock_evt),
    .count_o (relock_cnt_o)
  );

  assign lock_raw_o   = lock_sync;
  assign ser_enable_o = ovr_en_i ? ovr_val_i : locked_o;

  AST_COUNT_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (relock_cnt_o != $past(relock_cnt_o) && relock_cnt_o != '0) |-> $rose(locked_o)); // R6
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (!locked_o && relock_cnt_o == '0)); // R2
endmodule

// File: tb/pll_lock_filter_tb.sv
module pll_lock_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic [7:0] thr_a = 8'd5;
  logic [7:0] thr_d = 8'd3;
  logic       prst = 1'b0;
  logic       oen = 1'b0;
  logic       oval = 1'b0;
  logic       raw_o, lk_o, en_o;
  logic [7:0] cnt_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // reference model state
  int q[$];
  int m_lock = 0;
  int m_run = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  pll_lock_filter u_dut (
    .clk(clk), .rst_n(rst_n), .lock_raw_i(raw), .lock_dwell_i(thr_a),
    .unlock_dwell_i(thr_d), .pll_reset_i(prst), .ovr_en_i(oen), .ovr_val_i(oval),
    .lock_raw_o(raw_o), .locked_o(lk_o), .ser_enable_o(en_o), .relock_cnt_o(cnt_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q = {0, 0};
      m_lock = 0; m_run = 0; m_cnt = 0;
    end else begin
      int cur, thr, inc;
      cur = q[0];
      void'(q.pop_front());
      q.push_back(int'(raw));
      thr = m_lock ? int'(thr_d) : int'(thr_a);
      if (thr == 0) thr = 1;
      inc = 0;
      if (cur != m_lock) begin
        m_run++;
        if (m_run >= thr) begin
          m_lock = 1 - m_lock;
          m_run = 0;
          inc = m_lock;
        end
      end else m_run = 0;
      if (prst) m_cnt = 0;
      else if (inc == 1 && m_cnt < 255) m_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && q.size() == 2) begin
      int exp_en;
      exp_en = oen ? int'(oval) : m_lock;
      chk(int'(raw_o) == q[0], "R1 lock_raw_o", int'(raw_o), q[0]);
      chk(int'(lk_o) == m_lock, "R3,R4,R5 locked_o", int'(lk_o), m_lock);
      chk(int'(cnt_o) == m_cnt, "R6,R7,R8 relock_cnt_o", int'(cnt_o), m_cnt);
      chk(int'(en_o) == exp_en, "R9,R10 ser_enable_o", int'(en_o), exp_en);
    end
  end

  task automatic pulse(input bit v, input int n);
    raw = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(lk_o == 1'b0 && cnt_o == 8'd0 && en_o == 1'b0, "R2 reset", int'(lk_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lk_o == 1'b0 && cnt_o == 8'd0, "R2 after release", int'(cnt_o), 0);

    // R5: high glitch of 4 (< 5) never locks
    pulse(1, 4); pulse(0, 6);
    chk(lk_o == 1'b0, "R5 short high", int'(lk_o), 0);
    // R3: high for exactly 5 locks
    pulse(1, 5);
    @(negedge clk); @(negedge clk);
    chk(lk_o == 1'b1 && cnt_o == 8'd1, "R3 lock after dwell", int'(cnt_o), 1);
    // R5: low glitch of 2 (< 3)
    pulse(0, 2); pulse(1, 6);
    chk(lk_o == 1'b1, "R5 short low", int'(lk_o), 1);
    // R4: low for 3 unlocks
    pulse(0, 3); pulse(0, 3);
    chk(lk_o == 1'b0, "R4 unlock after dwell", int'(lk_o), 0);
    // R10 override while filter changes
    oen = 1'b1; oval = 1'b1;
    pulse(1, 8);
    chk(en_o == 1'b1, "R10 forced high", int'(en_o), 1);
    oval = 1'b0;
    @(negedge clk);
    chk(en_o == 1'b0 && lk_o == 1'b1, "R10 forced low", int'(en_o), 0);
    oen = 1'b0;
    @(negedge clk);
    chk(en_o == lk_o, "R9 follow", int'(en_o), int'(lk_o));
    // R7: pll reset clears, state unaffected
    prst = 1'b1; @(negedge clk); prst = 1'b0;
    chk(cnt_o == 8'd0 && lk_o == 1'b1, "R7 clear", int'(cnt_o), 0);
    // zero dwell acts as one
    thr_a = 8'd0; thr_d = 8'd0;
    pulse(0, 4); pulse(1, 4);
    chk(lk_o == 1'b1 && cnt_o == 8'd1, "R3 zero dwell", int'(cnt_o), 1);
    // R8 saturation
    thr_a = 8'd1; thr_d = 8'd1;
    for (int i = 0; i < 300; i++) begin
      pulse(0, 3); pulse(1, 3);
    end
    repeat (3) @(negedge clk);
    chk(cnt_o == 8'd255, "R8 saturate", int'(cnt_o), 255);
    // R7 clear coinciding with a relock edge handled by model
    pulse(0, 3); raw = 1'b1;
    @(negedge clk); @(negedge clk); prst = 1'b1; @(negedge clk); prst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_o == 8'd0, "R7 clear priority", int'(cnt_o), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule